// File: doc/BRIEF.md
# Dual-Issue Pairing and Scoreboard

This block sits between the pending queue of decoded instructions and the two execution pipes of an in-order integer core. Each cycle it looks at the two oldest decoded instructions and decides whether none, the first, or both may issue. It also assigns each issued instruction to pipe 0 or pipe 1. A per-register scoreboard counts down the cycles until each outstanding result can be consumed. Hazards are therefore resolved from fixed latencies, with no handshake from the execution units. A pair in which the second instruction reads the first one's result may still go together when forwarding can meet the consumer's timing.

When the memory system reports a miss for a memory instruction issued a fixed number of cycles earlier, the block does not stall. It drops everything in flight from that instruction onward into a replay buffer and blocks issue for a fixed penalty window. It then re-issues the buffered instructions in their original order before it accepts anything new from the queue.

The queue side is valid/ready, one pair of bits per slot. A descriptor must stay stable while its valid bit is high and its ready bit is low. When only slot 0 is taken, the queue moves its slot 1 descriptor into slot 0 for the next cycle. Slot 1 is valid only together with slot 0. The issue side has no back-pressure: an instruction flagged in `iss_vld` has left in that cycle.

Top module: `dual_issue_sched`

## Requirements
- R1: A descriptor is 21 bits. Reading from the top bit down: late-operand flag [20], result latency [19:17], write enable [16], destination [15:12], source-B used [11], source B [10:7], source-A used [6], source A [5:2], class [1:0]. Class codes: 0 ALU/shift/saturate, 1 multiply, 2 load, 3 store. The latency lies between 1 and 7.
- R2: `in_rdy[k]` is high exactly when the queue's slot-k descriptor issues. Slot 1 never issues without slot 0 in the same cycle. Nothing issues while `in_vld[0]` is low. Out of reset the scoreboard is empty, so independent instructions issue at once.
- R3: Take a producer of latency L issued in cycle t. A consumer that reads its destination with the late flag clear issues no earlier than t+L. An ALU result (L=1) therefore feeds the next cycle, and a load (L=2) costs one bubble.
- R4: A consumer with the late flag set may issue in cycle t+L-1, but never before t+1.
- R5: An instruction whose destination still has R cycles pending waits until R is less than its own latency.
- R6: A multiply issues only to pipe 0, and two multiplies never pair.
- R7: At most one load or store issues per cycle.
- R8: Two instructions that both write the same register never pair.
- R9: Slot 1 may read slot 0's destination in the same cycle only if slot 0 is an ALU instruction of latency 1 and slot 1 has the late flag set. Otherwise slot 1 is held.
- R10: `iss_pipe[k]` gives the pipe of slot k. A paired issue uses both pipes. A lone slot-0 issue uses pipe 0.
- R11: In the cycle `mem_miss` is high, and in the PEN-1 cycles after it (9 cycles in all with the default), nothing issues and `in_rdy` stays low.
- R12: At a miss, take the group issued MISS_DLY cycles earlier, from its memory instruction onward, together with every later issue. These are re-issued in their original order after the penalty, subject to the normal pairing rules, before any queue instruction is taken. The scoreboard is cleared at the miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 2 | Queue valid, bit k for slot k |
| in_rdy | output | 2 | Queue descriptor taken, bit k for slot k |
| in_ins0 | input | 21 | Oldest queued descriptor |
| in_ins1 | input | 21 | Second-oldest queued descriptor |
| mem_miss | input | 1 | Miss on the memory instruction issued MISS_DLY cycles earlier |
| iss_vld | output | 2 | Issue flag per slot |
| iss_pipe | output | 2 | Pipe index per slot |
| iss_ins0 | output | 21 | Descriptor issued in slot 0 |
| iss_ins1 | output | 21 | Descriptor issued in slot 1 |

## Verification
The assertions take the following for granted about the inputs:
- Slot 1 is valid only when slot 0 is.
- Every latency is at least 1.
- `mem_miss` rises only when the group issued MISS_DLY cycles earlier holds a load or store, and never while a penalty or replay is under way.

The stimulus keeps to these rules. It plants a memory instruction, idles out the remaining cycles of the delay, and only then raises the miss for one cycle. It presents single instructions or legal pairs, then drains the scoreboard with idle cycles before the next pattern.

// File: rtl/dip_pkg.sv
package dip_pkg;
  parameter int REG_W = 4;
  parameter int LAT_W = 3;
  localparam int NREG = 1 << REG_W;

  typedef enum logic [1:0] {
    CL_ALU = 2'd0,
    CL_MUL = 2'd1,
    CL_LD  = 2'd2,
    CL_ST  = 2'd3
  } cls_e;

  // most significant field first
  typedef struct packed {
    logic             late;
    logic [LAT_W-1:0] lat;
    logic             wr;
    logic [REG_W-1:0] dst;
    logic             useb;
    logic [REG_W-1:0] srcb;
    logic             usea;
    logic [REG_W-1:0] srca;
    cls_e             cls;
  } ins_t;

  localparam int INS_W = $bits(ins_t);

  // v[0] marks slot 0, v[1] marks slot 1
  typedef struct packed {
    logic [1:0] v;
    ins_t       i1;
    ins_t       i0;
  } grp_t;

  function automatic logic is_mem(ins_t x);
    return x.cls == CL_LD || x.cls == CL_ST;
  endfunction
endpackage

// File: rtl/dip_scoreboard.sv
module dip_scoreboard
  import dip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we0,
  input  logic [REG_W-1:0] wd0,
  input  logic [LAT_W-1:0] wl0,
  input  logic             we1,
  input  logic [REG_W-1:0] wd1,
  input  logic [LAT_W-1:0] wl1,
  output logic [LAT_W-1:0] cnt_o [NREG]
);
  // cnt_o[r] = cycles before a normal reader of r may issue
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [LAT_W-1:0] cnt_q;
    logic hit0, hit1;
    assign hit0 = we0 && (wd0 == REG_W'(r));
    assign hit1 = we1 && (wd1 == REG_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n)         cnt_q <= '0;
      else if (clr)       cnt_q <= '0;
      else if (hit0)      cnt_q <= wl0 - LAT_W'(1);
      else if (hit1)      cnt_q <= wl1 - LAT_W'(1);
      else if (cnt_q != 0) cnt_q <= cnt_q - LAT_W'(1);
    end
    assign cnt_o[r] = cnt_q;

    AST_SB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0); // R12
    AST_SB_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit0 && hit1)); // R8
  end
endmodule

// File: rtl/dip_pair_check.sv
module dip_pair_check
  import dip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cv,
  input  ins_t             c0,
  input  ins_t             c1,
  input  logic             block,
  input  logic [LAT_W-1:0] cnt_i [NREG],
  output logic             iss0,
  output logic             iss1,
  output logic             pipe0,
  output logic             pipe1
);
  function automatic logic rd_ok(logic used, logic [LAT_W-1:0] c, logic late);
    return !used || c == '0 || (late && c == LAT_W'(1));
  endfunction

  function automatic logic waw_ok(logic wr, logic [LAT_W-1:0] c, logic [LAT_W-1:0] lat);
    return !wr || c < lat;
  endfunction

  logic ok0, fwd_ok, dep_a, dep_b, a_ok, b_ok, cls_ok, same_dst;

  always_comb begin
    ok0 = cv[0] && !block
          && rd_ok(c0.usea, cnt_i[c0.srca], c0.late)
          && rd_ok(c0.useb, cnt_i[c0.srcb], c0.late)
          && waw_ok(c0.wr, cnt_i[c0.dst], c0.lat);
    fwd_ok   = (c0.cls == CL_ALU) && (c0.lat == LAT_W'(1)) && c1.late;
    dep_a    = c1.usea && c0.wr && (c1.srca == c0.dst);
    dep_b    = c1.useb && c0.wr && (c1.srcb == c0.dst);
    a_ok     = dep_a ? fwd_ok : rd_ok(c1.usea, cnt_i[c1.srca], c1.late);
    b_ok     = dep_b ? fwd_ok : rd_ok(c1.useb, cnt_i[c1.srcb], c1.late);
    cls_ok   = !(c0.cls == CL_MUL && c1.cls == CL_MUL) && !(is_mem(c0) && is_mem(c1));
    same_dst = c0.wr && c1.wr && (c0.dst == c1.dst);
    iss0  = ok0;
    iss1  = ok0 && cv[1] && a_ok && b_ok && cls_ok && !same_dst
            && waw_ok(c1.wr, cnt_i[c1.dst], c1.lat);
    pipe0 = iss1 && (c1.cls == CL_MUL);
    pipe1 = iss1 && !pipe0;
  end

  AST_MUL_PIPE0_S0: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && c0.cls == CL_MUL) |-> !pipe0); // R6
  AST_MUL_PIPE0_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1 && c1.cls == CL_MUL) |-> !pipe1); // R6
  AST_ONE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> !(is_mem(c0) && is_mem(c1))); // R7
  AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss1 && c0.wr && c1.wr) |-> c0.dst != c1.dst); // R8
  AST_PIPES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> pipe0 != pipe1); // R10
  AST_SLOT1_WITH_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    iss1 |-> iss0); // R2
endmodule

// File: rtl/dip_replay.sv
module dip_replay
  import dip_pkg::*;
#(
  parameter int PEN      = 9,
  parameter int MISS_DLY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_miss,
  input  logic       iss0,
  input  logic       iss1,
  input  ins_t       ii0,
  input  ins_t       ii1,
  output logic       pen_on,
  output logic       rp_any,
  output logic [1:0] rp_v,
  output ins_t       rp_i0,
  output ins_t       rp_i1
);
  localparam int PW = $clog2(PEN + 1);
  localparam int HW = (MISS_DLY > 1) ? $clog2(MISS_DLY) : 1;

  grp_t           hist [1:MISS_DLY];
  grp_t           rb   [MISS_DLY];
  logic [PW-1:0]  pen_q;
  grp_t           cur;
  logic [HW-1:0]  head;

  function automatic grp_t trim(grp_t g);
    grp_t t;
    t = g;
    if (g.v == 2'b11 && !is_mem(g.i0) && is_mem(g.i1)) begin
      t.v  = 2'b01;
      t.i0 = g.i1;
      t.i1 = '0;
    end
    return t;
  endfunction

  assign cur = '{v: {iss1, iss0}, i1: ii1, i0: ii0};

  // issue history, one group per cycle
  always_ff @(posedge clk) begin
    if (!rst_n) hist[1] <= '0;
    else        hist[1] <= cur;
  end
  for (genvar a = 2; a <= MISS_DLY; a++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) hist[a] <= '0;
      else        hist[a] <= hist[a-1];
    end
  end

  // oldest non-empty replay group
  always_comb begin
    head   = '0;
    rp_any = 1'b0;
    for (int i = MISS_DLY - 1; i >= 0; i--) begin
      if (rb[i].v != 2'b00) begin
        head   = HW'(i);
        rp_any = 1'b1;
      end
    end
    rp_v  = rb[head].v;
    rp_i0 = rb[head].i0;
    rp_i1 = rb[head].i1;
  end

  assign pen_on = pen_q != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_q <= '0;
      for (int i = 0; i < MISS_DLY; i++) rb[i] <= '0;
    end else if (mem_miss) begin
      pen_q <= PW'(PEN - 1);
      rb[0] <= trim(hist[MISS_DLY]);
      for (int i = 1; i < MISS_DLY; i++) rb[i] <= hist[MISS_DLY-i];
    end else if (pen_on) begin
      pen_q <= pen_q - PW'(1);
    end else if (rp_any && iss0) begin
      if (iss1 || !rb[head].v[1]) begin
        rb[head].v <= 2'b00;
      end else begin
        rb[head].v  <= 2'b01;
        rb[head].i0 <= rb[head].i1;
      end
    end
  end

  AST_MISS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_miss |-> !pen_on && !rp_any); // R11
  AST_MISS_HAS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_miss |-> (hist[MISS_DLY].v[0] && is_mem(hist[MISS_DLY].i0))
              || (hist[MISS_DLY].v[1] && is_mem(hist[MISS_DLY].i1))); // R12
  AST_PEN_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_on && !mem_miss) |=> pen_q == $past(pen_q) - PW'(1)); // R11
endmodule

// File: rtl/dual_issue_sched.sv
module dual_issue_sched
  import dip_pkg::*;
#(
  parameter int PEN      = 9,
  parameter int MISS_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       in_vld,
  output logic [1:0]       in_rdy,
  input  logic [INS_W-1:0] in_ins0,
  input  logic [INS_W-1:0] in_ins1,
  input  logic             mem_miss,
  output logic [1:0]       iss_vld,
  output logic [1:0]       iss_pipe,
  output logic [INS_W-1:0] iss_ins0,
  output logic [INS_W-1:0] iss_ins1
);
  ins_t             c0, c1, rp_i0, rp_i1;
  logic [1:0]       cv, rp_v;
  logic             pen_on, rp_any, block;
  logic             iss0, iss1, pipe0, pipe1;
  logic [LAT_W-1:0] cnt [NREG];

  // replayed work has priority over the queue
  always_comb begin
    if (rp_any) begin
      cv = rp_v;
      c0 = rp_i0;
      c1 = rp_i1;
    end else begin
      cv = in_vld;
      c0 = ins_t'(in_ins0);
      c1 = ins_t'(in_ins1);
    end
  end

  assign block = mem_miss || pen_on;

  dip_scoreboard u_sb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (mem_miss),
    .we0   (iss0 && c0.wr),
    .wd0   (c0.dst),
    .wl0   (c0.lat),
    .we1   (iss1 && c1.wr),
    .wd1   (c1.dst),
    .wl1   (c1.lat),
    .cnt_o (cnt)
  );

  dip_pair_check u_pair (
    .clk   (clk),
    .rst_n (rst_n),
    .cv    (cv),
    .c0    (c0),
    .c1    (c1),
    .block (block),
    .cnt_i (cnt),
    .iss0  (iss0),
    .iss1  (iss1),
    .pipe0 (pipe0),
    .pipe1 (pipe1)
  );

  dip_replay #(.PEN(PEN), .MISS_DLY(MISS_DLY)) u_rp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_miss (mem_miss),
    .iss0     (iss0),
    .iss1     (iss1),
    .ii0      (c0),
    .ii1      (c1),
    .pen_on   (pen_on),
    .rp_any   (rp_any),
    .rp_v     (rp_v),
    .rp_i0    (rp_i0),
    .rp_i1    (rp_i1)
  );

  assign iss_vld  = {iss1, iss0};
  assign iss_pipe = {pipe1, pipe0};
  assign iss_ins0 = c0;
  assign iss_ins1 = c1;
  assign in_rdy   = rp_any ? 2'b00 : {iss1, iss0};

  AST_SRC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && c0.usea && !c0.late) |-> cnt[c0.srca] == '0); // R3
  AST_LATE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && c0.usea && c0.late) |-> cnt[c0.srca] <= LAT_W'(1)); // R4
  AST_WAW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (iss0 && c0.wr) |-> cnt[c0.dst] < c0.lat); // R5
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    block |-> iss_vld == 2'b00 && in_rdy == 2'b00); // R11
  AST_QUEUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rp_any |-> in_rdy == 2'b00); // R12
  AST_SLOT1_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy[1] |-> in_rdy[0]); // R2
endmodule

// File: tb/sim_dual_issue_sched.sv
`timescale 1ns/1ps
module sim_dual_issue_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_vld = 2'b00;
  logic [1:0]  in_rdy;
  logic [20:0] in_ins0 = '0, in_ins1 = '0;
  logic        mem_miss = 1'b0;
  logic [1:0]  iss_vld, iss_pipe;
  logic [20:0] iss_ins0, iss_ins1;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dual_issue_sched u0 (.*);

  localparam int ALU = 0, MUL = 1, LD = 2, ST = 3;

  // layout per R1
  function automatic logic [20:0] mk(int cls, int sa, int ua, int sb, int ub,
                                     int d, int w, int lat, int late);
    return {late[0], lat[2:0], w[0], d[3:0], ub[0], sb[3:0], ua[0], sa[3:0], cls[1:0]};
  endfunction

  task automatic chk(string req, longint act, longint exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_vld = 2'b00;
    repeat (n) step();
  endtask

  task automatic present(logic [1:0] v, logic [20:0] a, logic [20:0] b);
    in_vld = v; in_ins0 = a; in_ins1 = b;
    #1;
  endtask

  // R3 R4: cycles from producer issue to consumer issue
  task automatic lat_probe(int lat, int late);
    int k = 0;
    int cls = (lat == 2) ? LD : ((lat >= 3) ? MUL : ALU);
    present(2'b01, mk(cls, 0, 0, 0, 0, 5, 1, lat, 0), '0);
    step();
    present(2'b01, mk(ALU, 5, 1, 0, 0, 6, 0, 1, late), '0);
    for (int i = 1; i <= 12; i++) begin
      if (iss_vld[0] && k == 0) k = i;
      if (k == 0) begin step(); #1; end
    end
    chk(late ? "R4" : "R3", k, late ? ((lat - 1 > 1) ? lat - 1 : 1) : lat,
        $sformatf("issue distance lat=%0d", lat));
    step();
    idle(8);
  endtask

  // R5: pending destination against the newcomer's latency
  task automatic waw_probe(int lat2);
    int k = 0;
    int e = 4 - lat2 + 1;
    present(2'b01, mk(MUL, 0, 0, 0, 0, 6, 1, 4, 0), '0);
    step();
    present(2'b01, mk(ALU, 0, 0, 0, 0, 6, 1, lat2, 0), '0);
    for (int i = 1; i <= 12; i++) begin
      if (iss_vld[0] && k == 0) k = i;
      if (k == 0) begin step(); #1; end
    end
    chk("R5", k, (e < 1) ? 1 : e, $sformatf("waw distance lat2=%0d", lat2));
    step();
    idle(8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state and idle
    present(2'b00, '0, '0);
    chk("R2", {in_rdy, iss_vld}, 4'b0000, "no valid no issue");
    present(2'b11, mk(ALU, 1, 1, 2, 1, 3, 1, 1, 0), mk(ALU, 4, 1, 5, 1, 6, 1, 1, 0));
    chk("R2", {in_rdy, iss_vld}, 4'b1111, "empty scoreboard pair after reset");
    step();
    idle(4);

    // R1 R6 R7 R10 class sweep
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic e1;
        logic [1:0] ep;
        e1 = !(a == MUL && b == MUL) && !(a >= LD && b >= LD);
        ep = !e1 ? 2'b00 : ((b == MUL) ? 2'b01 : 2'b10);
        present(2'b11, mk(a, 0, 0, 0, 0, 1, 1, 1, 0), mk(b, 0, 0, 0, 0, 2, 1, 1, 0));
        chk((a >= LD && b >= LD) ? "R7" : "R6", iss_vld, {e1, 1'b1},
            $sformatf("pairing cls %0d/%0d", a, b));
        chk("R10", iss_pipe, ep, $sformatf("pipes cls %0d/%0d", a, b));
        chk("R2", in_rdy, {e1, 1'b1}, "ready follows issue");
        step();
        idle(2);
      end
    end
    present(2'b01, mk(MUL, 0, 0, 0, 0, 1, 1, 1, 0), '0);
    chk("R10", {iss_vld, iss_pipe}, 4'b0100, "lone issue on pipe 0");
    step();
    idle(2);

    // R3 R4 latency sweep
    for (int l = 1; l <= 5; l++) begin
      lat_probe(l, 0);
      lat_probe(l, 1);
    end
    // R5
    for (int l2 = 1; l2 <= 5; l2++) waw_probe(l2);

    // R9 same-cycle dependency sweep
    for (int c = 0; c < 3; c++) begin
      for (int l = 1; l <= 2; l++) begin
        for (int lt = 0; lt < 2; lt++) begin
          for (int op = 0; op < 2; op++) begin
            logic e1;
            e1 = (c == ALU) && (l == 1) && (lt == 1);
            present(2'b11, mk(c, 0, 0, 0, 0, 7, 1, l, 0),
                    mk(ALU, op ? 0 : 7, op ? 0 : 1, op ? 7 : 0, op, 8, 1, 1, lt));
            chk("R9", iss_vld, {e1, 1'b1}, $sformatf("dep pair cls=%0d lat=%0d late=%0d", c, l, lt));
            step();
            idle(5);
          end
        end
      end
    end

    // R8
    present(2'b11, mk(ALU, 0, 0, 0, 0, 9, 1, 1, 0), mk(ALU, 0, 0, 0, 0, 9, 1, 1, 0));
    chk("R8", iss_vld, 2'b01, "same destination held");
    step();
    idle(2);
    present(2'b11, mk(ALU, 0, 0, 0, 0, 9, 1, 1, 0), mk(ALU, 0, 0, 0, 0, 9, 0, 1, 0));
    chk("R8", iss_vld, 2'b11, "second not writing pairs");
    step();
    idle(4);

    // R11 R12 replay with load in slot 0
    begin
      logic [20:0] ia, ib, ic, ie;
      ia = mk(LD, 0, 0, 0, 0, 1, 1, 2, 0);
      ib = mk(ALU, 0, 0, 0, 0, 2, 1, 1, 0);
      ic = mk(ALU, 0, 0, 0, 0, 3, 1, 1, 0);
      ie = mk(ALU, 0, 0, 0, 0, 4, 1, 1, 0);
      present(2'b11, ia, ib);
      chk("R12", iss_vld, 2'b11, "load pair issues");
      step();
      present(2'b01, ic, '0);
      step();
      idle(1);
      mem_miss = 1'b1;
      present(2'b01, ie, '0);
      chk("R11", {in_rdy, iss_vld}, 4'b0000, "quiet in miss cycle");
      step();
      mem_miss = 1'b0;
      for (int i = 1; i < 9; i++) begin
        #1;
        chk("R11", {in_rdy, iss_vld}, 4'b0000, $sformatf("quiet penalty cycle %0d", i));
        step();
      end
      #1;
      chk("R12", {in_rdy, iss_vld}, 4'b0011, "replay pair issues");
      chk("R12", {iss_ins0, iss_ins1}, {ia, ib}, "replay pair content");
      step();
      #1;
      chk("R12", {in_rdy, iss_vld}, 4'b0001, "replay second group alone");
      chk("R12", iss_ins0, ic, "replay second content");
      step();
      #1;
      chk("R12", {in_rdy, iss_vld}, 4'b0101, "queue resumes");
      chk("R12", iss_ins0, ie, "queue resumes content");
      step();
      idle(6);
    end

    // R12 replay with store in slot 1: only the store returns
    begin
      logic [20:0] ix, iy, ie;
      ix = mk(ALU, 0, 0, 0, 0, 5, 1, 1, 0);
      iy = mk(ST, 2, 1, 3, 1, 0, 0, 1, 0);
      ie = mk(MUL, 0, 0, 0, 0, 6, 1, 3, 0);
      present(2'b11, ix, iy);
      step();
      idle(2);
      mem_miss = 1'b1;
      present(2'b01, ie, '0);
      step();
      mem_miss = 1'b0;
      repeat (8) step();
      #1;
      chk("R12", {in_rdy, iss_vld, iss_ins0}, {4'b0001, iy}, "store replayed alone");
      step();
      #1;
      chk("R12", {in_rdy, iss_vld, iss_ins0}, {4'b0101, ie}, "queue after store replay");
      step();
      idle(4);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule